// File: doc/BRIEF.md
# Bank-switching memory address decoder

This block sits on the address bus of an 8-bit processor with a 16-bit address space. It sorts every valid bus cycle into exactly one of four regions: common RAM, I/O space, banked RAM and firmware EPROM. For the selected region it drives one chip select and forms the physical address that the memory behind it needs.

A single bank flip-flop lets two 48 KB EPROM images share the upper CPU window, and also selects one of two copies of the banked RAM region. Software flips the bank by writing to one of two adjacent I/O addresses. The address alone chooses the bank, so the block has no data input. The new bank applies from the bus cycle that follows the write. This lets code placed at the same address in both images hand control across the switch.

Top module: `bank_switch_decoder`

## Requirements
- R1: After reset the bank output is 0.
- R2: While valid is high, exactly one chip select is high. cs_cram is high for addresses 0000–1FFF, cs_io for 2000–27FF, cs_bram for 2800–3FFF and cs_rom for 4000–FFFF (hex).
- R3: While valid is low, all four chip selects are low.
- R4: A cycle with valid high, wr high and address 2169 sets the bank to 1. The next bus cycle already decodes with bank 1.
- R5: A cycle with valid high, wr high and address 2168 clears the bank to 0. The next bus cycle already decodes with bank 0.
- R6: The bank does not change on a read of 2168 or 2169, on a write to any other address, or on any cycle with valid low.
- R7: While cs_rom is high, rom_addr equals bank × C000 + (address − 4000), a 17-bit value. At all other times rom_addr is 0.
- R8: While cs_bram is high, bram_addr equals bank × 2000 + (address − 2800), so the bank bit sits at bit 13 above a 13-bit offset. At all other times bram_addr is 0.
- R9: While cs_cram is high, cram_addr equals the low 13 address bits whatever the bank. At all other times cram_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bank flip-flop updates on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the bank |
| addr | input | 16 | CPU address of the current bus cycle |
| wr | input | 1 | 1 for a write cycle, 0 for a read cycle |
| valid | input | 1 | High while the bus cycle is real |
| cs_cram | output | 1 | Select for common RAM |
| cs_io | output | 1 | Select for I/O space |
| cs_bram | output | 1 | Select for banked RAM |
| cs_rom | output | 1 | Select for firmware EPROM |
| cram_addr | output | 13 | Physical common RAM address |
| bram_addr | output | 14 | Physical banked RAM address |
| rom_addr | output | 17 | Physical EPROM address |
| bank | output | 1 | Current bank bit |

## Verification
The assertions assume that addr, wr and valid are stable around each rising clock edge. They also assume that one bus cycle lasts exactly one clock, so that a bank write is followed directly by the cycle that must see the new bank. The stimulus changes its inputs only on falling edges and holds each cycle for a full clock. It sweeps every address in both banks with reads, which never disturb the bank. The bank-changing writes are issued in separate, directed cycles.

// File: rtl/bank_switch_pkg.sv
package bank_switch_pkg;
   typedef enum logic [1:0] {
      REG_CRAM = 2'd0,
      REG_IO   = 2'd1,
      REG_BRAM = 2'd2,
      REG_ROM  = 2'd3
   } region_e;

   function automatic int unsigned span_width(input int unsigned span);
      return (span <= 1) ? 1 : $clog2(span);
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bank_region_decode.sv
module bank_region_decode
   import bank_switch_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IO_BASE   = 'h2000,
   parameter int unsigned BRAM_BASE = 'h2800,
   parameter int unsigned ROM_BASE  = 'h4000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              valid,
   output region_e           region,
   output logic [3:0]        sel
);
   localparam logic [ADDR_W-1:0] IO_B   = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] BRAM_B = ADDR_W'(BRAM_BASE);
   localparam logic [ADDR_W-1:0] ROM_B  = ADDR_W'(ROM_BASE);

   always_comb begin
      if (addr >= ROM_B)       region = REG_ROM;
      else if (addr >= BRAM_B) region = REG_BRAM;
      else if (addr >= IO_B)   region = REG_IO;
      else                     region = REG_CRAM;
   end

   genvar gi;
   generate
      for (gi = 0; gi < 4; gi++) begin : g_sel
         assign sel[gi] = valid && (region == region_e'(gi));
      end
   endgenerate
endmodule

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned SET_ADDR = 'h2169,
   parameter int unsigned CLR_ADDR = 'h2168
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              valid,
   output logic              bank_q
);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_ADDR);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

   logic wr_cyc;
   logic hit_set;
   logic hit_clr;

   assign wr_cyc  = valid && wr;
   assign hit_set = wr_cyc && (addr == SET_A);
   assign hit_clr = wr_cyc && (addr == CLR_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q <= 1'b0;
      else if (hit_set) bank_q <= 1'b1;
      else if (hit_clr) bank_q <= 1'b0;
   end
endmodule

// File: rtl/bank_phys_map.sv
module bank_phys_map
   import bank_switch_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BRAM_BASE = 'h2800,
   parameter int unsigned ROM_BASE  = 'h4000,
   parameter int unsigned CRAM_W    = 13,
   parameter int unsigned BRAM_W    = 13,
   parameter int unsigned ROM_W     = 17
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              bank,
   input  logic [3:0]        sel,
   output logic [CRAM_W-1:0] cram_addr,
   output logic [BRAM_W:0]   bram_addr,
   output logic [ROM_W-1:0]  rom_addr
);
   localparam int unsigned ROM_SPAN = (1 << ADDR_W) - ROM_BASE;
   localparam int unsigned ROMOFF_W = span_width(ROM_SPAN);

   logic [ADDR_W-1:0] bram_off;
   logic [ROM_W-1:0]  rom_off;
   logic [ROM_W-1:0]  rom_phys;

   assign bram_off = addr - ADDR_W'(BRAM_BASE);
   assign rom_off  = ROM_W'(addr) - ROM_W'(ROM_BASE);

   generate
      if (is_pow2(ROM_SPAN)) begin : g_rom_concat
         assign rom_phys = ROM_W'({bank, rom_off[ROMOFF_W-1:0]});
      end else begin : g_rom_adder
         assign rom_phys = bank ? (rom_off + ROM_W'(ROM_SPAN)) : rom_off;
      end
   endgenerate

   always_comb begin
      cram_addr = sel[REG_CRAM] ? addr[CRAM_W-1:0] : '0;
      bram_addr = sel[REG_BRAM] ? {bank, bram_off[BRAM_W-1:0]} : '0;
      rom_addr  = sel[REG_ROM]  ? rom_phys : '0;
   end
endmodule

// File: rtl/bank_switch_decoder.sv
module bank_switch_decoder
   import bank_switch_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IO_BASE   = 'h2000,
   parameter int unsigned BRAM_BASE = 'h2800,
   parameter int unsigned ROM_BASE  = 'h4000,
   parameter int unsigned SET_ADDR  = 'h2169,
   parameter int unsigned CLR_ADDR  = 'h2168,
   localparam int unsigned CRAM_W   = span_width(IO_BASE),
   localparam int unsigned BRAM_W   = span_width(ROM_BASE - BRAM_BASE),
   localparam int unsigned ROM_W    = span_width(2 * ((1 << ADDR_W) - ROM_BASE))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              valid,
   output logic              cs_cram,
   output logic              cs_io,
   output logic              cs_bram,
   output logic              cs_rom,
   output logic [CRAM_W-1:0] cram_addr,
   output logic [BRAM_W:0]   bram_addr,
   output logic [ROM_W-1:0]  rom_addr,
   output logic              bank
);
   generate
      if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_width
         $error("ADDR_W out of supported range");
      end
      if (!(IO_BASE > 0 && IO_BASE < BRAM_BASE && BRAM_BASE < ROM_BASE
            && ROM_BASE < (1 << ADDR_W))) begin : g_bad_order
         $error("region bases must ascend inside the address space");
      end
      if (SET_ADDR == CLR_ADDR) begin : g_bad_same
         $error("bank set and clear addresses must differ");
      end
      if (SET_ADDR < IO_BASE || SET_ADDR >= BRAM_BASE ||
          CLR_ADDR < IO_BASE || CLR_ADDR >= BRAM_BASE) begin : g_bad_io
         $error("bank registers must lie in I/O space");
      end
   endgenerate

   region_e    region;
   logic [3:0] sel;
   logic       bank_q;

   bank_region_decode #(
      .ADDR_W   (ADDR_W),
      .IO_BASE  (IO_BASE),
      .BRAM_BASE(BRAM_BASE),
      .ROM_BASE (ROM_BASE)
   ) u_decode (
      .addr  (addr),
      .valid (valid),
      .region(region),
      .sel   (sel)
   );

   bank_select_reg #(
      .ADDR_W  (ADDR_W),
      .SET_ADDR(SET_ADDR),
      .CLR_ADDR(CLR_ADDR)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wr    (wr),
      .valid (valid),
      .bank_q(bank_q)
   );

   bank_phys_map #(
      .ADDR_W   (ADDR_W),
      .BRAM_BASE(BRAM_BASE),
      .ROM_BASE (ROM_BASE),
      .CRAM_W   (CRAM_W),
      .BRAM_W   (BRAM_W),
      .ROM_W    (ROM_W)
   ) u_map (
      .addr     (addr),
      .bank     (bank_q),
      .sel      (sel),
      .cram_addr(cram_addr),
      .bram_addr(bram_addr),
      .rom_addr (rom_addr)
   );

   assign cs_cram = sel[REG_CRAM];
   assign cs_io   = sel[REG_IO];
   assign cs_bram = sel[REG_BRAM];
   assign cs_rom  = sel[REG_ROM];
   assign bank    = bank_q;
endmodule

// File: rtl/bank_switch_decoder_chk.sv
module bank_switch_decoder_chk #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned SET_ADDR = 'h2169,
   parameter int unsigned CLR_ADDR = 'h2168,
   parameter int unsigned CRAM_W   = 13,
   parameter int unsigned BRAM_W   = 13,
   parameter int unsigned ROM_W    = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr,
   input logic              valid,
   input logic              cs_cram,
   input logic              cs_io,
   input logic              cs_bram,
   input logic              cs_rom,
   input logic [CRAM_W-1:0] cram_addr,
   input logic [BRAM_W:0]   bram_addr,
   input logic [ROM_W-1:0]  rom_addr,
   input logic              bank
);
   logic [3:0] cs_vec;
   logic       is_set;
   logic       is_clr;
   assign cs_vec = {cs_rom, cs_bram, cs_io, cs_cram};
   assign is_set = (addr == ADDR_W'(SET_ADDR));
   assign is_clr = (addr == ADDR_W'(CLR_ADDR));

   assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ($countones(cs_vec) == 1));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (cs_vec == 4'b0000));

   assert_set_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && wr && is_set) |=> bank);

   assert_clr_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && wr && is_clr) |=> !bank);

   assert_hold_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && wr && (is_set || is_clr)) |=> $stable(bank));

   assert_rom_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rom |-> (rom_addr == '0));

   assert_bram_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_bram |-> (bram_addr[BRAM_W] == bank));

   assert_cram_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_cram |-> (cram_addr == '0));
endmodule

bind bank_switch_decoder bank_switch_decoder_chk #(
   .ADDR_W  (ADDR_W),
   .SET_ADDR(SET_ADDR),
   .CLR_ADDR(CLR_ADDR),
   .CRAM_W  (CRAM_W),
   .BRAM_W  (BRAM_W),
   .ROM_W   (ROM_W)
) u_chk (.*);

// File: tb/tb_bank_switch_decoder.sv
module tb_bank_switch_decoder;
   logic        clk;
   logic        rst_n;
   logic [15:0] addr;
   logic        wr;
   logic        valid;
   logic        cs_cram, cs_io, cs_bram, cs_rom;
   logic [12:0] cram_addr;
   logic [13:0] bram_addr;
   logic [16:0] rom_addr;
   logic        bank;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   bank_switch_decoder dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .valid(valid),
      .cs_cram(cs_cram), .cs_io(cs_io), .cs_bram(cs_bram), .cs_rom(cs_rom),
      .cram_addr(cram_addr), .bram_addr(bram_addr), .rom_addr(rom_addr),
      .bank(bank)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (addr %04h)", req, act, exp, addr);
      end
   endtask

   task automatic drive(input int a, input bit w, input bit v);
      @(negedge clk);
      addr  = 16'(a);
      wr    = w;
      valid = v;
      #1;
   endtask

   task automatic check_decode(input int a, input bit b);
      int ecs, ec, eb, er;
      ecs = (a >= 'h4000) ? 8 : (a >= 'h2800) ? 4 : (a >= 'h2000) ? 2 : 1;
      ec  = (ecs == 1) ? (a % 'h2000) : 0;
      eb  = (ecs == 4) ? (b * 'h2000 + (a - 'h2800)) : 0;
      er  = (ecs == 8) ? (b * 'hC000 + (a - 'h4000)) : 0;
      chk("R2", {28'd0, cs_rom, cs_bram, cs_io, cs_cram}, ecs);
      chk("R9", int'(cram_addr), ec);
      chk("R8", int'(bram_addr), eb);
      chk("R7", int'(rom_addr), er);
   endtask

   initial begin
      rst_n = 1'b0; addr = '0; wr = 1'b0; valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", int'(bank), 0);
      chk("R3", {28'd0, cs_rom, cs_bram, cs_io, cs_cram}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R3: idle cycles across regions select nothing
      for (int a = 0; a < 'h10000; a += 'h1357) begin
         drive(a, 1'b0, 1'b0);
         chk("R3", {28'd0, cs_rom, cs_bram, cs_io, cs_cram}, 0);
         chk("R7", int'(rom_addr), 0);
      end

      // full sweep in bank 0 with reads (R2 R7 R8 R9)
      for (int a = 0; a < 'h10000; a++) begin
         drive(a, 1'b0, 1'b1);
         check_decode(a, 1'b0);
      end
      chk("R6", int'(bank), 0);

      // R4: write the set address, next cycle decodes bank 1
      drive('h2169, 1'b1, 1'b1);
      chk("R4", int'(bank), 0);
      drive('h4000, 1'b0, 1'b1);
      chk("R4", int'(bank), 1);
      chk("R4", int'(rom_addr), 'hC000);

      // full sweep in bank 1
      for (int a = 0; a < 'h10000; a++) begin
         drive(a, 1'b0, 1'b1);
         check_decode(a, 1'b1);
      end

      // R6: read of clear address, neighbour write, idle write keep bank
      drive('h2168, 1'b0, 1'b1);
      drive('hFFFF, 1'b0, 1'b1);
      chk("R6", int'(bank), 1);
      chk("R6", int'(rom_addr), 'h17FFF);
      drive('h2167, 1'b1, 1'b1);
      drive('h216A, 1'b1, 1'b1);
      drive('h2168, 1'b1, 1'b0);
      drive('h3FFF, 1'b0, 1'b1);
      chk("R6", int'(bank), 1);
      chk("R8", int'(bram_addr), 'h37FF);

      // R5: clear, next cycle decodes bank 0
      drive('h2168, 1'b1, 1'b1);
      drive('hFFFF, 1'b0, 1'b1);
      chk("R5", int'(bank), 0);
      chk("R5", int'(rom_addr), 'hBFFF);

      // R6: read of set address and idle write keep bank 0
      drive('h2169, 1'b0, 1'b1);
      drive('h2169, 1'b1, 1'b0);
      drive('h2800, 1'b0, 1'b1);
      chk("R6", int'(bank), 0);
      chk("R8", int'(bram_addr), 0);

      // R4 then R5 back to back
      drive('h2169, 1'b1, 1'b1);
      drive('h2168, 1'b1, 1'b1);
      chk("R4", int'(bank), 1);
      drive('h1FFF, 1'b0, 1'b1);
      chk("R5", int'(bank), 0);
      chk("R9", int'(cram_addr), 'h1FFF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule